// File: doc/BRIEF.md
# Half-duplex single-wire synchronous serial port

This block moves one 8-bit byte at a time over a single bidirectional data line, timed by a separate bit clock line. A transmit/receive bit in the control register sets which way the data line points. In master mode the port makes the bit clock itself from the system clock, at one of four rates. In slave mode it follows a bit clock supplied by the other device, after passing it through a synchronizer. The CPU reaches the port through a small read/write bus with three registers: control at address 0, status at address 1 and data at address 2. Address 3 reads as zero.

A master transfer starts when the CPU writes the data register while the port is enabled. In receive, that write only starts the clock, and the data line stays an input. Each bit is sampled on the leading clock edge, which moves the clock away from its idle level. The next bit is shifted on the trailing edge, which returns the clock to idle. A single shift register serves both directions, so after every transfer the data register holds the eight sampled line levels. A status flag marks the end of each byte. Writes made at the wrong moment are either ignored or flagged.

Top module: `hdx_serial_port`

## Requirements
- R1: After reset the control register reads 0x08, status reads 0x00, both output enables are low and `xfer_done` is low. Control layout: bit 0 enable, bit 1 transmit (1) / receive (0), bit 2 master (1) / slave (0), bit 3 MSB-first (1) / LSB-first (0), bit 4 clock idle level, bits 6:5 rate, bit 7 reads 0.
- R2: Master transmit, MSB-first: bit 7 is on `line_out` before the first leading edge. Each trailing edge presents the next lower bit, and exactly 8 leading edges occur.
- R3: The master bit period is 4, 8, 16 or 32 system clocks for rate 0 to 3. `xfer_done` rises 8 bit periods after the clock edge that accepts the data write.
- R4: With bit 3 clear, bits go out and come in LSB first.
- R5: In master receive (bit 1 clear), a data write starts the clock while `line_oe` stays low. The byte sampled on the leading edges is read back from the data register, in the order that bit 3 selects.
- R6: With bit 4 set, the clock idles high and the leading edge is the falling edge. With bit 4 clear, it idles low and the leading edge is the rising edge.
- R7: In slave receive, `bclk_in` and `line_in` supplied from outside are sampled on the leading edges and assembled into the data register.
- R8: In slave transmit, a byte written before the enable is set shows its first bit on `line_out`, with `line_oe` high, as soon as the port is enabled. The later bits follow the external trailing edges.
- R9: Status bit 7 and `xfer_done` set when the eighth trailing edge completes. A data-register access on its own does not clear them. A status read that sees a flag set, followed by a data-register access, clears them.
- R10: A data write during a transfer sets status bit 6 and leaves the shifted byte unchanged. Because the data line level is sampled in both directions, a transmitted byte reads back intact.
- R11: During a transfer, a control write with bit 0 set changes nothing. A control write with bit 0 clear disables the port, aborts the transfer, releases both output enables and leaves status bit 7 clear.
- R12: While the port is enabled and idle, control writes update only bits 0 and 1. Rate, idle level, bit order and master select keep their values.
- R13: `line_oe` is high only when the port is enabled and set to transmit. `bclk_oe` is high only when the port is enabled and set to master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives read side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| line_out | output | 1 | Data line output value |
| line_oe | output | 1 | Data line output enable |
| line_in | input | 1 | Data line pad level |
| bclk_out | output | 1 | Bit clock output value |
| bclk_oe | output | 1 | Bit clock output enable |
| bclk_in | input | 1 | Bit clock pad level (slave mode) |
| xfer_done | output | 1 | Transfer-complete flag |

## Verification
The hardest situations to reach are the register writes that land in the middle of a byte: a control write that must be ignored, a control write that aborts, and a data write that raises the collision flag. Directed sequences start a slow master transfer at the largest divider. They wait a fixed number of cycles to land well inside it, and only then issue the write. The bench models the data pad as a loopback of `line_out` whenever `line_oe` is high. This lets a transmitted byte be read back, which shows at the bus that a colliding write did not corrupt the shift register. Random bytes, rates, bit orders, idle levels and the four master/slave × direction combinations are then mixed around these cases.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

  localparam int unsigned RATE_W = 2;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int unsigned S_DONE = 7;
  localparam int unsigned S_WCOL = 6;

  // packed order equals the control register bit layout (bit 0 = en)
  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              pol;
    logic              msb;
    logic              mst;
    logic              tx;
    logic              en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{rate: '0, pol: 1'b0, msb: 1'b1,
                                 mst: 1'b0, tx: 1'b0, en: 1'b0};

endpackage

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
  import hsp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              xfer_end,
  input  logic [DATA_W-1:0] shift_q,
  output ctrl_t             ctrl_q,
  output logic              load,
  output logic [DATA_W-1:0] load_val,
  output logic              start,
  output logic              abort,
  output logic              done_q,
  output logic              wcol_q
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_d, wr_cfg;
  logic  done_d, wcol_d, arm_q, arm_d;
  logic  wr_ctrl, wr_data, rd_stat, acc_data;
  logic [DATA_W-1:0] stat_word;

  assign wr_ctrl  = bus_sel & bus_wr & (bus_addr == A_CTRL);
  assign wr_data  = bus_sel & bus_wr & (bus_addr == A_DATA);
  assign rd_stat  = bus_sel & bus_rd & (bus_addr == A_STAT);
  assign acc_data = bus_sel & (bus_wr | bus_rd) & (bus_addr == A_DATA);
  assign wr_cfg   = ctrl_t'(bus_wdata[CTRL_W-1:0]);

  assign load     = wr_data & ~busy;
  assign load_val = bus_wdata;
  assign start    = load & ctrl_q.en & ctrl_q.mst;

  // control write rules: busy -> only disable; enabled -> en/tx only
  always_comb begin
    ctrl_d = ctrl_q;
    abort  = 1'b0;
    if (wr_ctrl) begin
      if (busy) begin
        if (!wr_cfg.en) begin
          ctrl_d.en = 1'b0;
          abort     = 1'b1;
        end
      end else if (ctrl_q.en) begin
        ctrl_d.en = wr_cfg.en;
        ctrl_d.tx = wr_cfg.tx;
      end else begin
        ctrl_d = wr_cfg;
      end
    end
  end

  // status flags: set wins over the read-then-access clear
  always_comb begin
    done_d = done_q;
    wcol_d = wcol_q;
    arm_d  = arm_q;
    if (acc_data && arm_q) begin
      done_d = 1'b0;
      wcol_d = 1'b0;
      arm_d  = 1'b0;
    end
    if (rd_stat && (done_q || wcol_q)) arm_d = 1'b1;
    if (wr_data && busy)               wcol_d = 1'b1;
    if (xfer_end)                      done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      done_q <= 1'b0;
      wcol_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      done_q <= done_d;
      wcol_q <= wcol_d;
      arm_q  <= arm_d;
    end
  end

  always_comb begin
    stat_word         = '0;
    stat_word[S_DONE] = done_q;
    stat_word[S_WCOL] = wcol_q;
    unique case (bus_addr)
      A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
      A_STAT:  bus_rdata = stat_word;
      A_DATA:  bus_rdata = shift_q;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/hsp_clkgen.sv
module hsp_clkgen #(
  parameter int unsigned RATE_W = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mst,
  input  logic              pol,
  input  logic [RATE_W-1:0] rate,
  input  logic              busy,
  input  logic              ext_clk,
  output logic              lead,
  output logic              trail,
  output logic              clk_out
);

  localparam int unsigned HALF_MAX = 2 << ((1 << RATE_W) - 1);
  localparam int unsigned CW       = $clog2(HALF_MAX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic [CW:0]   half_w;
  logic          tick, m_lead, m_trail, s_lead, s_trail;
  logic [SYNC_N:0] sync_q;
  logic          lvl_new, lvl_old;

  // master half-period is 2 << rate system clocks
  assign half_w = (CW+1)'(2) << rate;
  assign tick   = ({1'b0, cnt_q} == (half_w - (CW+1)'(1)));

  always_comb begin
    cnt_d   = cnt_q;
    ph_d    = ph_q;
    m_lead  = 1'b0;
    m_trail = 1'b0;
    if (!(busy && mst)) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (tick) begin
      cnt_d   = '0;
      ph_d    = ~ph_q;
      m_lead  = ~ph_q;
      m_trail = ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      sync_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      sync_q <= {sync_q[SYNC_N-1:0], ext_clk};
    end
  end

  // slave edges on the synchronized clock, normalized to idle level
  assign lvl_new = sync_q[SYNC_N-1] ^ pol;
  assign lvl_old = sync_q[SYNC_N] ^ pol;
  assign s_lead  = en & ~mst & lvl_new & ~lvl_old;
  assign s_trail = en & ~mst & busy & ~lvl_new & lvl_old;

  assign lead    = mst ? m_lead  : s_lead;
  assign trail   = mst ? m_trail : s_trail;
  assign clk_out = pol ^ (ph_q & busy);

endmodule

// File: rtl/hsp_shifter.sv
module hsp_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              start,
  input  logic              abort,
  input  logic              lead,
  input  logic              trail,
  input  logic              msb,
  input  logic              din,
  output logic              busy,
  output logic              xfer_end,
  output logic [DATA_W-1:0] shift_q,
  output logic              dout
);

  localparam int unsigned BCW = $clog2(DATA_W);

  logic [DATA_W-1:0] shift_d;
  logic [BCW-1:0]    bit_q, bit_d;
  logic              busy_d, samp_q, samp_d;

  assign xfer_end = busy & trail & (bit_q == BCW'(DATA_W - 1));

  always_comb begin
    shift_d = shift_q;
    bit_d   = bit_q;
    busy_d  = busy;
    samp_d  = samp_q;
    if (abort) begin
      busy_d = 1'b0;
      bit_d  = '0;
    end else begin
      if (load) shift_d = load_val;
      if (start || lead) busy_d = 1'b1;
      if (lead) samp_d = din;
      if (trail && busy) begin
        shift_d = msb ? {shift_q[DATA_W-2:0], samp_q}
                      : {samp_q, shift_q[DATA_W-1:1]};
        if (xfer_end) begin
          busy_d = 1'b0;
          bit_d  = '0;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bit_q   <= '0;
      busy    <= 1'b0;
      samp_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      bit_q   <= bit_d;
      busy    <= busy_d;
      samp_q  <= samp_d;
    end
  end

  assign dout = msb ? shift_q[DATA_W-1] : shift_q[0];

endmodule

// File: rtl/hdx_serial_port.sv
module hdx_serial_port
  import hsp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              line_out,
  output logic              line_oe,
  input  logic              line_in,
  output logic              bclk_out,
  output logic              bclk_oe,
  input  logic              bclk_in,
  output logic              xfer_done
);

  logic [1:0]        rst_pipe;
  logic              rst_q;
  ctrl_t             ctrl_q;
  logic              load, start, abort, busy, xfer_end, lead, trail;
  logic              done_q, wcol_q;
  logic [DATA_W-1:0] load_val, shift_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  hsp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_q),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .xfer_end(xfer_end), .shift_q(shift_q),
    .ctrl_q(ctrl_q), .load(load), .load_val(load_val),
    .start(start), .abort(abort), .done_q(done_q), .wcol_q(wcol_q)
  );

  hsp_clkgen #(.RATE_W(RATE_W), .SYNC_N(SYNC_N)) u_clkgen (
    .clk(clk), .rst_n(rst_q),
    .en(ctrl_q.en), .mst(ctrl_q.mst), .pol(ctrl_q.pol), .rate(ctrl_q.rate),
    .busy(busy), .ext_clk(bclk_in),
    .lead(lead), .trail(trail), .clk_out(bclk_out)
  );

  hsp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_q),
    .load(load), .load_val(load_val), .start(start), .abort(abort),
    .lead(lead), .trail(trail), .msb(ctrl_q.msb), .din(line_in),
    .busy(busy), .xfer_end(xfer_end), .shift_q(shift_q), .dout(line_out)
  );

  assign line_oe   = ctrl_q.en & ctrl_q.tx;
  assign bclk_oe   = ctrl_q.en & ctrl_q.mst;
  assign xfer_done = done_q;

endmodule

// File: rtl/hsp_checker.sv
module hsp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       wd_en,
  input logic [6:0] cfg,
  input logic       busy,
  input logic       done,
  input logic       wcol,
  input logic       line_out,
  input logic       line_oe,
  input logic       bclk_out,
  input logic       bclk_oe
);

  logic wr_ctrl, wr_data;
  assign wr_ctrl = bus_sel & bus_wr & (bus_addr == 2'd0);
  assign wr_data = bus_sel & bus_wr & (bus_addr == 2'd2);

  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  // R10
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> wcol);

  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl && wd_en) |=> $stable(cfg));

  // R11
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl && !wd_en) |=> (!busy && !line_oe && !bclk_oe && !done));

  // R12
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0] && !busy && wr_ctrl) |=> $stable(cfg[6:2]));

  // R2
  shift_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[2] && busy && $past(busy) && line_oe && $past(line_oe) && !$stable(line_out))
      |-> (bclk_out == cfg[4]));

endmodule

bind hdx_serial_port hsp_checker u_chk (
  .clk(clk), .rst_n(rst_q),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd_en(bus_wdata[0]), .cfg(ctrl_q),
  .busy(busy), .done(done_q), .wcol(wcol_q),
  .line_out(line_out), .line_oe(line_oe),
  .bclk_out(bclk_out), .bclk_oe(bclk_oe)
);

// File: tb/sim_hdx_serial_port.sv
`timescale 1ns/1ps
module sim_hdx_serial_port;

  logic       clk;
  logic       rst_n;
  logic       bus_sel, bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       line_out, line_oe, bclk_out, bclk_oe, xfer_done;
  logic       drv_line, drv_clk;
  logic       line_in, bclk_in;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         ended = 0;

  // pad model: driven level wins, otherwise the external device
  assign line_in = line_oe ? line_out : drv_line;
  assign bclk_in = bclk_oe ? bclk_out : drv_clk;

  hdx_serial_port u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_out(line_out), .line_oe(line_oe), .line_in(line_in),
    .bclk_out(bclk_out), .bclk_oe(bclk_oe), .bclk_in(bclk_in),
    .xfer_done(xfer_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    summary();
  end

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg_byte(input logic [1:0] rate, input logic pol,
      input logic msb, input logic mst, input logic tx, input logic en);
    return {1'b0, rate, pol, msb, mst, tx, en};
  endfunction

  function automatic logic bit_at(input logic [7:0] b, input int i, input logic msb);
    return msb ? b[7-i] : b[i];
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic cfg_port(input logic [7:0] c);
    bus_write(2'd0, 8'h00);
    bus_write(2'd0, c & 8'hFE);
    bus_write(2'd0, c);
  endtask

  // R9 flag sequence, returns data register contents
  task automatic finish_xfer(input string tag, output logic [7:0] d);
    logic [7:0] s;
    check({tag, " R9 done set"}, xfer_done, xfer_done, 1);
    bus_read(2'd2, d);
    check({tag, " R9 data access alone keeps flag"}, xfer_done, xfer_done, 1);
    bus_read(2'd1, s);
    check({tag, " R9 status bit7"}, s[7], s, 8'h80);
    bus_read(2'd2, d);
    check({tag, " R9 flag cleared"}, !xfer_done, xfer_done, 0);
  endtask

  task automatic run_mtx(input logic [7:0] b, input logic [1:0] rate, input logic msb, input logic pol);
    int div = 4 << rate;
    int cyc = 0, leads = 0, last = 0, bad_per = 0;
    logic prev;
    logic [7:0] got = '0;
    logic [7:0] d;
    cfg_port(cfg_byte(rate, pol, msb, 1'b1, 1'b1, 1'b1));
    check("R6 idle level", bclk_out == pol && bclk_oe, bclk_out, pol);
    check("R13 oe when enabled tx master", line_oe && bclk_oe, {line_oe, bclk_oe}, 3);
    bus_write(2'd2, b);
    prev = bclk_out;
    while (!xfer_done && cyc < 4000) begin
      @(negedge clk); cyc++;
      if (bclk_out != prev && bclk_out != pol) begin
        if (leads < 8) got[msb ? 7 - leads : leads] = line_out;
        if (leads > 0 && cyc - last != div) bad_per++;
        last = cyc; leads++;
      end
      prev = bclk_out;
    end
    check(msb ? "R2 msb-first byte on line" : "R4 lsb-first byte on line", got == b, got, b);
    check("R2 eight leading edges", leads == 8, leads, 8);
    check("R3 bit period", bad_per == 0, bad_per, 0);
    check("R3 transfer length", cyc == 8 * div, cyc, 8 * div);
    finish_xfer("mtx", d);
  endtask

  task automatic run_mrx(input logic [7:0] b, input logic [1:0] rate, input logic msb, input logic pol);
    int cyc = 0, k = 0, oe_bad = 0;
    logic prev;
    logic [7:0] d;
    cfg_port(cfg_byte(rate, pol, msb, 1'b1, 1'b0, 1'b1));
    drv_line = bit_at(b, 0, msb);
    bus_write(2'd2, 8'h5A);
    prev = bclk_out;
    while (!xfer_done && cyc < 4000) begin
      @(negedge clk); cyc++;
      if (line_oe) oe_bad++;
      if (bclk_out != prev && bclk_out == pol) begin
        k++;
        if (k < 8) drv_line = bit_at(b, k, msb);
      end
      prev = bclk_out;
    end
    check("R5 line stays input", oe_bad == 0, oe_bad, 0);
    check("R3 receive transfer length", cyc == 8 * (4 << rate), cyc, 8 * (4 << rate));
    finish_xfer("mrx", d);
    check(msb ? "R5 received byte" : "R4 received lsb-first", d == b, d, b);
  endtask

  task automatic run_srx(input logic [7:0] b, input logic msb, input logic pol);
    logic [7:0] d;
    drv_clk = pol;
    cfg_port(cfg_byte(2'd0, pol, msb, 1'b0, 1'b0, 1'b1));
    check("R13 slave rx no drivers", !line_oe && !bclk_oe, {line_oe, bclk_oe}, 0);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv_line = bit_at(b, i, msb);
      repeat (8) @(negedge clk);
      drv_clk = ~pol;
      repeat (8) @(negedge clk);
      drv_clk = pol;
    end
    repeat (6) @(negedge clk);
    finish_xfer("srx", d);
    check("R7 slave received byte", d == b, d, b);
  endtask

  task automatic run_stx(input logic [7:0] b, input logic msb, input logic pol);
    logic [7:0] got = '0;
    logic [7:0] d;
    drv_clk = pol;
    bus_write(2'd0, 8'h00);
    bus_write(2'd0, cfg_byte(2'd0, pol, msb, 1'b0, 1'b1, 1'b0));
    bus_write(2'd2, b);
    bus_write(2'd0, cfg_byte(2'd0, pol, msb, 1'b0, 1'b1, 1'b1));
    check("R8 first bit at enable", line_oe && line_out == bit_at(b, 0, msb),
          {line_oe, line_out}, {1'b1, bit_at(b, 0, msb)});
    for (int i = 0; i < 8; i++) begin
      repeat (8) @(negedge clk);
      got[msb ? 7 - i : i] = line_out;
      drv_clk = ~pol;
      repeat (8) @(negedge clk);
      drv_clk = pol;
    end
    repeat (6) @(negedge clk);
    check("R8 slave sent byte", got == b, got, b);
    finish_xfer("stx", d);
  endtask

  initial begin
    logic [7:0] r;
    int cyc;
    void'($urandom(32'h0C0FFEE5));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    drv_line = 0; drv_clk = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 oe low", !line_oe && !bclk_oe && !xfer_done, {line_oe, bclk_oe, xfer_done}, 0);
    bus_read(2'd0, r); check("R1 control reset", r == 8'h08, r, 8'h08);
    bus_read(2'd1, r); check("R1 status reset", r == 8'h00, r, 8'h00);

    // R13 disabled port drives nothing
    bus_write(2'd0, cfg_byte(2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0));
    check("R13 disabled releases", !line_oe && !bclk_oe, {line_oe, bclk_oe}, 0);

    // directed main paths
    run_mtx(8'hA3, 2'd0, 1'b1, 1'b0);
    run_mtx(8'h1E, 2'd2, 1'b0, 1'b1);
    run_mrx(8'hC5, 2'd1, 1'b1, 1'b0);
    run_srx(8'h6B, 1'b0, 1'b1);
    run_stx(8'hD2, 1'b1, 1'b0);

    // R12 enabled idle: only en/tx take a write
    cfg_port(cfg_byte(2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1));
    bus_write(2'd0, cfg_byte(2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
    bus_read(2'd0, r);
    check("R12 config locked", r == cfg_byte(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1),
          r, cfg_byte(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1));

    // R10 collision during a slow transfer
    cfg_port(cfg_byte(2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1));
    bus_write(2'd2, 8'h96);
    repeat (20) @(negedge clk);
    bus_write(2'd2, 8'h00);
    bus_read(2'd1, r);
    check("R10 collision flag", r == 8'h40, r, 8'h40);
    cyc = 0;
    while (!xfer_done && cyc < 1000) begin @(negedge clk); cyc++; end
    bus_read(2'd1, r);
    bus_read(2'd2, r);
    check("R10 byte intact", r == 8'h96, r, 8'h96);
    bus_read(2'd1, r);
    check("R10 flags cleared", r == 8'h00, r, 8'h00);

    // R11 control writes during a transfer
    cfg_port(cfg_byte(2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1));
    bus_write(2'd2, 8'h3C);
    repeat (40) @(negedge clk);
    bus_write(2'd0, cfg_byte(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    bus_read(2'd0, r);
    check("R11 busy write ignored", r == cfg_byte(2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1),
          r, cfg_byte(2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1));
    bus_write(2'd0, cfg_byte(2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0));
    check("R11 abort releases pins", !line_oe && !bclk_oe, {line_oe, bclk_oe}, 0);
    repeat (300) @(negedge clk);
    bus_read(2'd1, r);
    check("R11 no done after abort", r == 8'h00 && !xfer_done, r, 8'h00);

    // random mix
    for (int n = 0; n < 12; n++) begin
      logic [7:0] b = 8'($urandom);
      logic [1:0] rt = 2'($urandom);
      logic ms = 1'($urandom);
      logic pl = 1'($urandom);
      case ($urandom % 4)
        0: run_mtx(b, rt, ms, pl);
        1: run_mrx(b, rt, ms, pl);
        2: run_srx(b, ms, pl);
        default: run_stx(b, ms, pl);
      endcase
    end

    summary();
  end

endmodule